// File: doc/BRIEF.md
# Instruction-Pair Skip Fetch Redirector

This block sits on the fetch path between a three-stage core that executes 16-bit instructions and a program memory with two read ports. It holds a small table of pre-identified instruction pairs. Each pair is a short run of consecutive instructions whose net effect is one 32-bit value written to one register. When the core's registered program counter lands on the first instruction of a listed pair, the block raises an invoke signal in the same cycle. It addresses the memory's second port with the instruction that follows the pair, and it steers that port's data into the fetch word. It also overrides the core's next program-counter values and presents the pair's precomputed result and destination register, so the whole pair disappears from the instruction stream without a bubble.

A pair either falls through or ends in a branch. For a fall-through pair the redirect address is the current PC plus the pair length in bytes. For a branch-ending pair it is the stored branch target, and the core then also avoids its three-cycle branch flush. The match uses the registered PC rather than the next-PC value. A taken branch or a pop into the PC loads the register directly, and only the registered PC sees every arrival at a pair.

The table is written through a plain write port while the enable input is low. With the enable low the block is fully transparent, and the core behaves like an unmodified one.

Top module: `pair_skip_redirector`

## Requirements
- R1: After a synchronous active-low reset every table entry is invalid, so invoke is low, fetch_word equals mem_a_rdata and pc_d/npc_d equal core_pc_d/core_npc_d for any PC.
- R2: With accel_en high, invoke is high in the same cycle in which pc equals the start address of a valid entry, and low otherwise.
- R3: fetch_instr is fetch_word[15:0] when bit 1 of the fetch address is 0 and fetch_word[31:16] when it is 1. The fetch address is the redirect address while invoking and pc otherwise.
- R4: For a matched entry with its branch flag at 0, mem_b_addr equals pc plus the entry's byte size, modulo 2^16.
- R5: For a matched entry with its branch flag at 1, mem_b_addr equals the entry's target address.
- R6: fetch_word equals mem_b_rdata while invoke is high and mem_a_rdata while it is low.
- R7: While invoking, pc_d equals the redirect address + 2 and npc_d equals the redirect address + 4, both modulo 2^16. Otherwise pc_d equals core_pc_d and npc_d equals core_npc_d.
- R8: While invoking, pair_result and pair_dest carry the matched entry's result and register index. Otherwise both are zero.
- R9: With accel_en low, invoke stays low even when pc equals a valid entry's start address.
- R10: Table writes presented while accel_en is high are ignored: the table content is unchanged afterwards.
- R11: When several valid entries share the start address, the entry with the lowest index supplies the redirect, result and register index.
- R12: An entry written with its valid bit at 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accel_en | input | 1 | Static enable; low makes the block transparent and opens the table for writes |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Entry index to write |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_branch | input | 1 | 1 = pair ends in a branch |
| tbl_size | input | 4 | Pair length in bytes |
| tbl_start | input | 16 | Address of the pair's first instruction |
| tbl_target | input | 16 | Branch target of a branch-ending pair |
| tbl_result | input | 32 | Precomputed pair result |
| tbl_dest | input | 4 | Destination register index |
| pc | input | 16 | Core's registered program counter |
| core_pc_d | input | 16 | Value the core would load into its PC |
| core_npc_d | input | 16 | Value the core would load as next-PC |
| mem_a_rdata | input | 32 | First memory port read data |
| mem_b_rdata | input | 32 | Second memory port read data |
| invoke | output | 1 | A pair starts at pc and is being skipped |
| mem_b_addr | output | 16 | Second memory port byte address |
| fetch_word | output | 32 | Selected fetch word |
| fetch_instr | output | 16 | Selected halfword of the fetch word |
| pc_d | output | 16 | PC load value after override |
| npc_d | output | 16 | Next-PC load value after override |
| pair_result | output | 32 | Result of the skipped pair |
| pair_dest | output | 4 | Register index for pair_result |

## Verification
The table is filled with a branch-ending pair whose target is word-aligned and a fall-through pair whose successor sits in an upper halfword. It also holds two entries that share one start address and one entry stored as invalid. The PC sequence then visits every start address and some near misses on both halfword positions. This separates the branch-target redirect from the add-size redirect, the upper from the lower halfword select, priority from a plain match, and a real hit from an invalid entry. Directed cases cover the enable held low, writes presented while enabled, an override that wraps past the top of the address space, and a reset after loading.

// File: rtl/pskip_pkg.sv
// Shared widths and the pair-table entry type for the fetch redirector.
// Assumes 16-bit instructions packed two per 32-bit fetch word.
package pskip_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned REG_W  = 4;
    localparam int unsigned SIZE_W = 4;
    localparam int unsigned INSN_W = 16;

    typedef struct packed {
        logic              valid;
        logic              ends_branch;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] target;
        logic [DATA_W-1:0] result;
        logic [REG_W-1:0]  dest;
    } pair_ent_t;
endpackage

// File: rtl/pskip_table.sv
// Pair table storage. Holds ENTRIES entries in flops.
// Assumes writes are only meaningful while the block is disabled; writes
// presented while enabled are dropped.
module pskip_table
    import pskip_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accel_en,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  pair_ent_t                 wr_ent,
    output pair_ent_t [ENTRIES-1:0]   ents
);
    pair_ent_t [ENTRIES-1:0] ents_q;

    // Store one entry per accepted write; reset invalidates everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else if (wr_en && !accel_en) begin
            ents_q[wr_idx] <= wr_ent;
        end
    end

    assign ents = ents_q;

    // R10: contents frozen across any cycle in which the block is enabled
    a_r10_frozen_when_enabled: assert property (
        @(posedge clk) disable iff (!rst_n)
        accel_en |=> $stable(ents_q)
    );
endmodule

// File: rtl/pskip_match.sv
// Compares the registered PC with every valid entry's start address and
// picks the lowest-index match. Purely combinational.
module pskip_match
    import pskip_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accel_en,
    input  logic [ADDR_W-1:0]         pc,
    input  pair_ent_t [ENTRIES-1:0]   ents,
    output logic                      hit,
    output logic                      hit_branch,
    output logic [SIZE_W-1:0]         hit_size,
    output logic [ADDR_W-1:0]         hit_target,
    output logic [DATA_W-1:0]         hit_result,
    output logic [REG_W-1:0]          hit_dest
);
    logic [ENTRIES-1:0] raw;
    pair_ent_t          sel;
    logic [ADDR_W-1:0]  sel_start;

    // One comparator per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign raw[i] = ents[i].valid && (ents[i].start == pc);
    end

    // Priority select: scanning downwards leaves the lowest index in place.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (raw[i]) sel = ents[i];
        end
    end

    assign hit        = accel_en && (|raw);
    assign hit_branch = sel.ends_branch;
    assign hit_size   = sel.size;
    assign hit_target = sel.target;
    assign hit_result = sel.result;
    assign hit_dest   = sel.dest;
    assign sel_start  = sel.start;

    // R2/R12: a reported hit always comes from a valid entry starting at pc
    a_r2_hit_is_valid_start: assert property (
        @(posedge clk) disable iff (!rst_n)
        hit |-> (sel.valid && sel_start == pc)
    );
endmodule

// File: rtl/pskip_steer.sv
// Forms the redirect address, drives the second memory port, selects the
// fetch word and halfword, and applies the PC overrides on a hit.
// Assumes memory read data arrives in the same cycle as its address.
module pskip_steer
    import pskip_pkg::*;
(
    input  logic               hit,
    input  logic               hit_branch,
    input  logic [SIZE_W-1:0]  hit_size,
    input  logic [ADDR_W-1:0]  hit_target,
    input  logic [DATA_W-1:0]  hit_result,
    input  logic [REG_W-1:0]   hit_dest,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  core_pc_d,
    input  logic [ADDR_W-1:0]  core_npc_d,
    input  logic [DATA_W-1:0]  mem_a_rdata,
    input  logic [DATA_W-1:0]  mem_b_rdata,
    output logic [ADDR_W-1:0]  mem_b_addr,
    output logic [DATA_W-1:0]  fetch_word,
    output logic [INSN_W-1:0]  fetch_instr,
    output logic [ADDR_W-1:0]  pc_d,
    output logic [ADDR_W-1:0]  npc_d,
    output logic [DATA_W-1:0]  pair_result,
    output logic [REG_W-1:0]   pair_dest
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] redir;
    logic [ADDR_W-1:0] fetch_addr;

    // Successor of the pair: branch target or the fall-through address.
    always_comb begin
        if (hit_branch) redir = hit_target;
        else            redir = pc + {{(ADDR_W-SIZE_W){1'b0}}, hit_size};
    end

    // Port steering and PC overrides.
    always_comb begin
        mem_b_addr  = hit ? redir : pc;
        fetch_addr  = hit ? redir : pc;
        fetch_word  = hit ? mem_b_rdata : mem_a_rdata;
        pc_d        = hit ? redir + STEP : core_pc_d;
        npc_d       = hit ? redir + STEP + STEP : core_npc_d;
        pair_result = hit ? hit_result : '0;
        pair_dest   = hit ? hit_dest : '0;
    end

    // Halfword select by address bit 1.
    always_comb begin
        if (fetch_addr[1]) fetch_instr = fetch_word[DATA_W-1 -: INSN_W];
        else               fetch_instr = fetch_word[INSN_W-1:0];
    end
endmodule

// File: rtl/pair_skip_redirector.sv
// Top of the instruction-pair skip fetch redirector: table, matcher and
// steering. Assumes pc is the core's registered PC and that the caller
// only writes the table while accel_en is low.
module pair_skip_redirector
    import pskip_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accel_en,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic               tbl_valid,
    input  logic               tbl_branch,
    input  logic [SIZE_W-1:0]  tbl_size,
    input  logic [ADDR_W-1:0]  tbl_start,
    input  logic [ADDR_W-1:0]  tbl_target,
    input  logic [DATA_W-1:0]  tbl_result,
    input  logic [REG_W-1:0]   tbl_dest,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  core_pc_d,
    input  logic [ADDR_W-1:0]  core_npc_d,
    input  logic [DATA_W-1:0]  mem_a_rdata,
    input  logic [DATA_W-1:0]  mem_b_rdata,
    output logic               invoke,
    output logic [ADDR_W-1:0]  mem_b_addr,
    output logic [DATA_W-1:0]  fetch_word,
    output logic [INSN_W-1:0]  fetch_instr,
    output logic [ADDR_W-1:0]  pc_d,
    output logic [ADDR_W-1:0]  npc_d,
    output logic [DATA_W-1:0]  pair_result,
    output logic [REG_W-1:0]   pair_dest
);
    pair_ent_t               wr_ent;
    pair_ent_t [ENTRIES-1:0] ents;
    logic                    hit_branch;
    logic [SIZE_W-1:0]       hit_size;
    logic [ADDR_W-1:0]       hit_target;
    logic [DATA_W-1:0]       hit_result;
    logic [REG_W-1:0]        hit_dest;

    // Assemble the write-port fields into one entry.
    always_comb begin
        wr_ent.valid       = tbl_valid;
        wr_ent.ends_branch = tbl_branch;
        wr_ent.size        = tbl_size;
        wr_ent.start       = tbl_start;
        wr_ent.target      = tbl_target;
        wr_ent.result      = tbl_result;
        wr_ent.dest        = tbl_dest;
    end

    pskip_table #(.ENTRIES(ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_ent(wr_ent), .ents(ents)
    );

    pskip_match #(.ENTRIES(ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .pc(pc), .ents(ents),
        .hit(invoke), .hit_branch(hit_branch), .hit_size(hit_size),
        .hit_target(hit_target), .hit_result(hit_result), .hit_dest(hit_dest)
    );

    pskip_steer u_steer (
        .hit(invoke), .hit_branch(hit_branch), .hit_size(hit_size),
        .hit_target(hit_target), .hit_result(hit_result), .hit_dest(hit_dest),
        .pc(pc), .core_pc_d(core_pc_d), .core_npc_d(core_npc_d),
        .mem_a_rdata(mem_a_rdata), .mem_b_rdata(mem_b_rdata),
        .mem_b_addr(mem_b_addr), .fetch_word(fetch_word),
        .fetch_instr(fetch_instr), .pc_d(pc_d), .npc_d(npc_d),
        .pair_result(pair_result), .pair_dest(pair_dest)
    );

    // R9: disabled block never invokes
    a_r9_quiet_when_disabled: assert property (
        @(posedge clk) disable iff (!rst_n)
        !accel_en |-> !invoke
    );

    // R6: fetch word comes from the second port exactly while invoking
    a_r6_fetch_from_b: assert property (
        @(posedge clk) disable iff (!rst_n)
        invoke |-> fetch_word == mem_b_rdata
    );

    // R7: PC override lands two bytes past the second-port address
    a_r7_pc_follows_b_addr: assert property (
        @(posedge clk) disable iff (!rst_n)
        invoke |-> (pc_d == mem_b_addr + ADDR_W'(2) && npc_d == pc_d + ADDR_W'(2))
    );

    // R7: no override without a hit
    a_r7_pass_through: assert property (
        @(posedge clk) disable iff (!rst_n)
        !invoke |-> (pc_d == core_pc_d && npc_d == core_npc_d && fetch_word == mem_a_rdata)
    );
endmodule

// File: tb/pair_skip_redirector_tb_top.sv
`timescale 1ns/1ps
module pair_skip_redirector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        accel_en;
    logic        tbl_we;
    logic [3:0]  tbl_idx;
    logic        tbl_valid;
    logic        tbl_branch;
    logic [3:0]  tbl_size;
    logic [15:0] tbl_start;
    logic [15:0] tbl_target;
    logic [31:0] tbl_result;
    logic [3:0]  tbl_dest;
    logic [15:0] pc;
    logic [15:0] core_pc_d;
    logic [15:0] core_npc_d;
    logic [31:0] mem_a_rdata;
    logic [31:0] mem_b_rdata;
    logic        invoke;
    logic [15:0] mem_b_addr;
    logic [31:0] fetch_word;
    logic [15:0] fetch_instr;
    logic [15:0] pc_d;
    logic [15:0] npc_d;
    logic [31:0] pair_result;
    logic [3:0]  pair_dest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] WORD_A = 32'h1111_2222;
    localparam logic [31:0] WORD_B = 32'h3333_4444;

    // Vector: pc, expected invoke, expected redirect, result, register
    localparam int NV = 7;
    localparam logic [68:0] VEC [NV] = '{
        {16'h0088, 1'b1, 16'h0040, 32'hDEAD_0001, 4'd3},
        {16'h0100, 1'b1, 16'h0106, 32'h1234_5678, 4'd7},
        {16'h0200, 1'b1, 16'h0204, 32'h0000_0202, 4'd2},
        {16'h0300, 1'b0, 16'h0000, 32'h0000_0000, 4'd0},
        {16'h0402, 1'b1, 16'h0406, 32'hCAFE_0005, 4'd5},
        {16'h008A, 1'b0, 16'h0000, 32'h0000_0000, 4'd0},
        {16'h0084, 1'b0, 16'h0000, 32'h0000_0000, 4'd0}
    };

    pair_skip_redirector dut_i (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_branch(tbl_branch),
        .tbl_size(tbl_size), .tbl_start(tbl_start), .tbl_target(tbl_target),
        .tbl_result(tbl_result), .tbl_dest(tbl_dest), .pc(pc),
        .core_pc_d(core_pc_d), .core_npc_d(core_npc_d),
        .mem_a_rdata(mem_a_rdata), .mem_b_rdata(mem_b_rdata),
        .invoke(invoke), .mem_b_addr(mem_b_addr), .fetch_word(fetch_word),
        .fetch_instr(fetch_instr), .pc_d(pc_d), .npc_d(npc_d),
        .pair_result(pair_result), .pair_dest(pair_dest)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic v, input logic br,
                      input logic [3:0] sz, input logic [15:0] st,
                      input logic [15:0] tg, input logic [31:0] res,
                      input logic [3:0] dst);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_valid = v; tbl_branch = br;
        tbl_size = sz; tbl_start = st; tbl_target = tg; tbl_result = res;
        tbl_dest = dst;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_pc(input logic [15:0] p);
        @(negedge clk);
        pc = p; core_pc_d = p + 16'd2; core_npc_d = p + 16'd4;
        #2;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; accel_en = 1'b0; tbl_we = 1'b0; tbl_idx = '0;
        tbl_valid = 1'b0; tbl_branch = 1'b0; tbl_size = '0; tbl_start = '0;
        tbl_target = '0; tbl_result = '0; tbl_dest = '0;
        pc = '0; core_pc_d = '0; core_npc_d = '0;
        mem_a_rdata = WORD_A; mem_b_rdata = WORD_B;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset, even with the enable on
        accel_en = 1'b1;
        set_pc(16'h0088);
        chk("R1", "invoke", 32'(invoke), 32'd0);
        chk("R1", "fetch_word", fetch_word, WORD_A);
        chk("R1", "pc_d", 32'(pc_d), 32'h008A);
        chk("R1", "npc_d", 32'(npc_d), 32'h008C);
        accel_en = 1'b0;

        // Load the table
        wr(4'd0, 1'b1, 1'b1, 4'd4, 16'h0088, 16'h0040, 32'hDEAD_0001, 4'd3);
        wr(4'd1, 1'b1, 1'b0, 4'd6, 16'h0100, 16'h0000, 32'h1234_5678, 4'd7);
        wr(4'd2, 1'b1, 1'b0, 4'd4, 16'h0200, 16'h0000, 32'h0000_0202, 4'd2);
        wr(4'd3, 1'b1, 1'b1, 4'd4, 16'h0200, 16'h0500, 32'h0000_0303, 4'd9);
        wr(4'd4, 1'b0, 1'b1, 4'd4, 16'h0300, 16'h0600, 32'h0000_0404, 4'd4);
        wr(4'd5, 1'b1, 1'b0, 4'd4, 16'h0402, 16'h0000, 32'hCAFE_0005, 4'd5);

        // R9: disabled with a loaded table
        set_pc(16'h0088);
        chk("R9", "invoke", 32'(invoke), 32'd0);
        chk("R9", "fetch_word", fetch_word, WORD_A);
        chk("R9", "pc_d", 32'(pc_d), 32'h008A);
        chk("R8", "pair_result idle", pair_result, 32'd0);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R11 R12
        accel_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [15:0] vpc, vrd, fa;
            logic        vinv;
            logic [31:0] w;
            vpc = VEC[v][68:53]; vinv = VEC[v][52]; vrd = VEC[v][51:36];
            set_pc(vpc);
            chk("R2", "invoke", 32'(invoke), 32'(vinv));
            fa = vinv ? vrd : vpc;
            w  = vinv ? WORD_B : WORD_A;
            chk("R6", "fetch_word", fetch_word, w);
            chk("R3", "fetch_instr", 32'(fetch_instr),
                32'(fa[1] ? w[31:16] : w[15:0]));
            chk("R8", "pair_result", pair_result, VEC[v][35:4]);
            chk("R8", "pair_dest", 32'(pair_dest), 32'(VEC[v][3:0]));
            if (vinv) begin
                chk("R4", "mem_b_addr (R5 R11 on branch/priority rows)",
                    32'(mem_b_addr), 32'(vrd));
                chk("R7", "pc_d", 32'(pc_d), 32'(vrd + 16'd2));
                chk("R7", "npc_d", 32'(npc_d), 32'(vrd + 16'd4));
            end else begin
                chk("R7", "pc_d pass", 32'(pc_d), 32'(vpc + 16'd2));
                chk("R7", "npc_d pass", 32'(npc_d), 32'(vpc + 16'd4));
            end
        end

        // R12: invalid entry at 0x0300 explicitly
        set_pc(16'h0300);
        chk("R12", "invoke", 32'(invoke), 32'd0);

        // R10: writes while enabled are dropped
        wr(4'd0, 1'b1, 1'b0, 4'd2, 16'h0700, 16'h0000, 32'h0000_0077, 4'd1);
        set_pc(16'h0700);
        chk("R10", "invoke new start", 32'(invoke), 32'd0);
        set_pc(16'h0088);
        chk("R10", "invoke old start", 32'(invoke), 32'd1);
        chk("R10", "old result kept", pair_result, 32'hDEAD_0001);

        // R5 + R7 wrap: branch pair whose target sits at top of space
        accel_en = 1'b0;
        wr(4'd6, 1'b1, 1'b1, 4'd4, 16'h0700, 16'hFFFE, 32'h0000_0066, 4'd6);
        accel_en = 1'b1;
        set_pc(16'h0700);
        chk("R5", "mem_b_addr", 32'(mem_b_addr), 32'hFFFE);
        chk("R7", "pc_d wrap", 32'(pc_d), 32'h0000);
        chk("R7", "npc_d wrap", 32'(npc_d), 32'h0002);
        chk("R3", "upper half at target", 32'(fetch_instr), 32'h3333);

        // R1: reset clears a loaded table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        set_pc(16'h0088);
        chk("R1", "invoke after reset", 32'(invoke), 32'd0);
        chk("R1", "pair_dest after reset", 32'(pair_dest), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule